// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the pending-interrupt flags and the per-source enable mask for the two timers of a small microcontroller. Four sources feed it as single-cycle event pulses: timer1 overflow, timer1 compare match A, timer1 input capture and timer0 overflow. Each pulse sets a sticky flag. The flag stays set until the CPU writes a one to it through the byte-wide register port, or until the CPU acknowledges that flag's interrupt vector.

Each flag is combined with its enable bit and with a global interrupt enable to form a request. When several requests are pending, the arbiter presents the one with the lowest vector number. Software sees two byte registers, selected by a one-bit address: the flag register and the mask register. Both use the same bit positions for each source. The timers, the capture unit and the CPU are outside this block. When timer1 runs in PWM mode, the overflow event must be pulsed at the point where the counter turns around at zero.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, all flags and all enable bits are zero, both registers read 8'h00, `irq_req` is 0 and `irq_vec` is 0.
- R2: An event pulse sets its flag on the next clock edge. The flag register (address 0) shows timer1 overflow at bit 7, compare match A at bit 6, input capture at bit 3 and timer0 overflow at bit 1.
- R3: A write to address 0 clears every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: Bits 5, 4, 2 and 0 of both registers always read zero, and writing them has no effect on any state.
- R5: A write to address 1 loads the enable bits: bit 7 for timer1 overflow, bit 6 for compare match A, bit 3 for input capture and bit 1 for timer0 overflow. Reads of address 1 return these bits.
- R6: A source requests an interrupt only when its flag, its enable bit and `glob_ie` are all one. `irq_req` is the OR of all source requests.
- R7: With default parameters, the vectors are input capture 3, compare match A 4, timer1 overflow 5 and timer0 overflow 6. `irq_vec` presents the lowest-numbered pending vector.
- R8: When `irq_ack` is high, the flag whose vector equals `ack_vec` is cleared on that edge. All other flags are unaffected.
- R9: If an event arrives in the same cycle as a write-one clear or an acknowledge of the same flag, the flag ends up set.
- R10: `irq_vec` is zero whenever `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_t1_ovf | input | 1 | Timer1 overflow pulse (in PWM mode: turnaround at zero) |
| ev_t1_cmpa | input | 1 | Timer1 compare match A pulse |
| ev_t1_cap | input | 1 | Timer1 input capture pulse |
| ev_t0_ovf | input | 1 | Timer0 overflow pulse |
| reg_addr | input | 1 | Register select: 0 flags, 1 mask |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| glob_ie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Any enabled request pending |
| irq_vec | output | VEC_W | Vector of the highest-priority request |
| irq_ack | input | 1 | CPU acknowledges vector `ack_vec` |
| ack_vec | input | VEC_W | Vector being acknowledged |

## Verification
The bench targets same-cycle collisions between a set event and a clear, whether the clear comes from a write of one or from an acknowledge. A design that let the clear win would lose an interrupt. It also writes all ones to the reserved bits: a design that stored them would read nonzero bits back. Acknowledges that match a different vector, or no vector at all, are checked so that a loose vector compare would be caught wiping out unrelated flags. Several pending requests are raised together to catch a reversed priority order, and `glob_ie` is toggled to show that it gates every request.

// File: rtl/tmr_irq_pkg.sv
// Shared constants for the timer interrupt flag controller.
// Source indices are internal; bit positions follow the register layout.
package tmr_irq_pkg;
    localparam int NSRC        = 4;
    localparam int SRC_T1OVF   = 0;
    localparam int SRC_T1CMPA  = 1;
    localparam int SRC_T1CAP   = 2;
    localparam int SRC_T0OVF   = 3;
    localparam logic ADDR_FLAG = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    // Register bit position of a source (same in both registers).
    function automatic int src_pos(input int s);
        case (s)
            SRC_T1OVF:  return 7;
            SRC_T1CMPA: return 6;
            SRC_T1CAP:  return 3;
            default:    return 1;
        endcase
    endfunction

    // Byte with ones at every implemented position.
    function automatic logic [7:0] impl_bits();
        logic [7:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) m[src_pos(s)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
// Sticky flag bank. Each flag is set by its event pulse and cleared either by
// a write of one at its register position or by an acknowledge of its vector.
// Assumes events are single-cycle; a set beats a clear in the same cycle.
module tmr_irq_flags #(
    parameter int                            NSRC    = 4,
    parameter int                            VEC_W   = 4,
    parameter logic [NSRC*VEC_W-1:0]         VEC_TAB = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  ev,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic             ack,
    input  logic [VEC_W-1:0] ack_vec,
    output logic [NSRC-1:0]  flag_q
);
    logic [7:0] unused_wdata;
    assign unused_wdata = wdata & ~tmr_irq_pkg::impl_bits();

    for (genvar s = 0; s < NSRC; s++) begin : g_flag
        localparam int POS = tmr_irq_pkg::src_pos(s);
        logic clr_wr;
        logic clr_ack;
        assign clr_wr  = wr_en && wdata[POS];
        assign clr_ack = ack && (ack_vec == VEC_TAB[s*VEC_W +: VEC_W]);

        // Per-flag update: reset, set on event, else clear on write or ack.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[s] <= 1'b0;
            else if (ev[s])
                flag_q[s] <= 1'b1;
            else if (clr_wr || clr_ack)
                flag_q[s] <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_irq_mask.sv
// Enable mask register. Loads implemented positions on a write; reserved
// positions are not stored at all.
module tmr_irq_mask #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wdata,
    output logic [NSRC-1:0] mask_q
);
    logic [7:0] unused_wdata;
    assign unused_wdata = wdata & ~tmr_irq_pkg::impl_bits();

    for (genvar s = 0; s < NSRC; s++) begin : g_en
        localparam int POS = tmr_irq_pkg::src_pos(s);
        // Per-source enable bit: reset to zero, load on mask write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[s] <= 1'b0;
            else if (wr_en)
                mask_q[s] <= wdata[POS];
        end
    end
endmodule

// File: rtl/tmr_irq_arb.sv
// Fixed-priority selector: among active requests, present the smallest
// vector number. Vector numbers come from the table, so the priority order
// follows them. Outputs zero when nothing is requested.
module tmr_irq_arb #(
    parameter int                    NSRC    = 4,
    parameter int                    VEC_W   = 4,
    parameter logic [NSRC*VEC_W-1:0] VEC_TAB = '0
) (
    input  logic [NSRC-1:0]  req,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    // Linear minimum search over pending vectors.
    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (!irq_req || VEC_TAB[s*VEC_W +: VEC_W] < irq_vec)) begin
                irq_req = 1'b1;
                irq_vec = VEC_TAB[s*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Timer interrupt flag controller top. Gathers the four event pulses, holds
// flags and enables, decodes the byte register port and drives the request
// and vector towards the CPU. Reads are combinational on reg_addr.
module tmr_irq_ctrl #(
    parameter int VEC_W       = 4,
    parameter int VEC_T1_CAP  = 3,
    parameter int VEC_T1_CMPA = 4,
    parameter int VEC_T1_OVF  = 5,
    parameter int VEC_T0_OVF  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_t1_ovf,
    input  logic             ev_t1_cmpa,
    input  logic             ev_t1_cap,
    input  logic             ev_t0_ovf,
    input  logic             reg_addr,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             glob_ie,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic [VEC_W-1:0] ack_vec
);
    import tmr_irq_pkg::*;

    localparam logic [NSRC*VEC_W-1:0] VEC_TAB = {
        VEC_W'(VEC_T0_OVF), VEC_W'(VEC_T1_CAP),
        VEC_W'(VEC_T1_CMPA), VEC_W'(VEC_T1_OVF)};

    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] req;
    logic [7:0]      flag_byte;
    logic [7:0]      mask_byte;
    logic            wr_flag;
    logic            wr_mask;

    assign ev_vec[SRC_T1OVF]  = ev_t1_ovf;
    assign ev_vec[SRC_T1CMPA] = ev_t1_cmpa;
    assign ev_vec[SRC_T1CAP]  = ev_t1_cap;
    assign ev_vec[SRC_T0OVF]  = ev_t0_ovf;

    assign wr_flag = reg_wr_en && (reg_addr == ADDR_FLAG);
    assign wr_mask = reg_wr_en && (reg_addr == ADDR_MASK);

    tmr_irq_flags #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_TAB(VEC_TAB)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .wr_en(wr_flag),
        .wdata(reg_wdata), .ack(irq_ack), .ack_vec(ack_vec), .flag_q(flag_q));

    tmr_irq_mask #(.NSRC(NSRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mask),
        .wdata(reg_wdata), .mask_q(mask_q));

    assign req = flag_q & mask_q & {NSRC{glob_ie}};

    tmr_irq_arb #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_TAB(VEC_TAB)) u_arb (
        .req(req), .irq_req(irq_req), .irq_vec(irq_vec));

    // Scatter flag and enable bits into their byte positions; rest stay zero.
    always_comb begin
        flag_byte = '0;
        mask_byte = '0;
        for (int s = 0; s < NSRC; s++) begin
            flag_byte[src_pos(s)] = flag_q[s];
            mask_byte[src_pos(s)] = mask_q[s];
        end
    end

    // Read multiplexer on the register address.
    always_comb begin
        reg_rdata = (reg_addr == ADDR_MASK) ? mask_byte : flag_byte;
    end
endmodule

// File: rtl/tmr_irq_chk.sv
// Assertion checker for tmr_irq_ctrl, attached by bind below.
module tmr_irq_chk #(
    parameter int VEC_W  = 4,
    parameter int VEC_T0 = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       ev,
    input logic [3:0]       flag_q,
    input logic [3:0]       mask_q,
    input logic             reg_addr,
    input logic             reg_wr_en,
    input logic [7:0]       reg_rdata,
    input logic             glob_ie,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic [VEC_W-1:0] ack_vec
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 8'h35) == 8'h00); // R4
    AST_REQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (glob_ie && (flag_q & mask_q) != 4'b0)); // R6
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != 4'b0) |=> ((flag_q & $past(ev)) == $past(ev))); // R9
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == 4'b0 && !irq_ack && !(reg_wr_en && reg_addr == 1'b0))
        |=> (flag_q == $past(flag_q))); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && ack_vec == VEC_W'(VEC_T0) && !ev[3]) |=> !flag_q[3]); // R8
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0)); // R10
endmodule

bind tmr_irq_ctrl tmr_irq_chk #(.VEC_W(VEC_W), .VEC_T0(VEC_T0_OVF)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .flag_q(flag_q), .mask_q(mask_q),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata),
    .glob_ie(glob_ie), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .ack_vec(ack_vec));

// File: tb/test_tmr_irq_ctrl.sv
// Self-checking bench: random traffic plus directed corners against a model.
module test_tmr_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_t1_ovf = 0, ev_t1_cmpa = 0, ev_t1_cap = 0, ev_t0_ovf = 0;
    logic       reg_addr = 0, reg_wr_en = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       glob_ie = 0;
    logic       irq_req;
    logic [3:0] irq_vec;
    logic       irq_ack = 0;
    logic [3:0] ack_vec = '0;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_flag = '0;   // order: t1ovf, cmpa, cap, t0ovf
    logic [3:0] m_mask = '0;

    always #4 clk = ~clk;

    tmr_irq_ctrl i_tmr_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_t1_ovf(ev_t1_ovf), .ev_t1_cmpa(ev_t1_cmpa),
        .ev_t1_cap(ev_t1_cap), .ev_t0_ovf(ev_t0_ovf), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glob_ie(glob_ie), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .ack_vec(ack_vec));

    function automatic int pos_of(input int s);
        return (s == 0) ? 7 : (s == 1) ? 6 : (s == 2) ? 3 : 1;
    endfunction
    function automatic logic [3:0] vec_of(input int s);
        return (s == 0) ? 4'd5 : (s == 1) ? 4'd4 : (s == 2) ? 4'd3 : 4'd6;
    endfunction
    function automatic logic [7:0] to_byte(input logic [3:0] b);
        logic [7:0] r = '0;
        for (int s = 0; s < 4; s++) r[pos_of(s)] = b[s];
        return r;
    endfunction
    function automatic logic [4:0] exp_irq(input logic [3:0] f, input logic [3:0] m, input logic g);
        logic [3:0] best = '0;
        logic       any = 1'b0;
        for (int s = 0; s < 4; s++)
            if (f[s] && m[s] && g && (!any || vec_of(s) < best)) begin
                any = 1'b1; best = vec_of(s);
            end
        return {any, best};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check after it.
    task automatic step(input logic [3:0] ev, input logic wr, input logic a,
                        input logic [7:0] wd, input logic ack, input logic [3:0] av,
                        input logic g, input string tag);
        logic [4:0] e;
        @(negedge clk);
        {ev_t0_ovf, ev_t1_cap, ev_t1_cmpa, ev_t1_ovf} = ev;
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        irq_ack = ack; ack_vec = av; glob_ie = g;
        @(posedge clk);
        for (int s = 0; s < 4; s++) begin
            if (ev[s]) m_flag[s] = 1'b1;
            else if ((wr && !a && wd[pos_of(s)]) || (ack && av == vec_of(s))) m_flag[s] = 1'b0;
            if (wr && a) m_mask[s] = wd[pos_of(s)];
        end
        #2;
        {ev_t0_ovf, ev_t1_cap, ev_t1_cmpa, ev_t1_ovf} = '0;
        reg_wr_en = 0; irq_ack = 0;
        reg_addr = 1'b0; #0.5;
        chk({tag, " R2/R3/R8 flags"}, reg_rdata, to_byte(m_flag));
        reg_addr = 1'b1; #0.5;
        chk({tag, " R5 mask"}, reg_rdata, to_byte(m_mask));
        e = exp_irq(m_flag, m_mask, g);
        chk({tag, " R6/R7/R10 irq"}, {3'b0, irq_req, irq_vec}, {3'b0, e});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        reg_addr = 1'b0; #0.5;
        chk("R1 flag reset", reg_rdata, 8'h00);
        reg_addr = 1'b1; #0.5;
        chk("R1 mask reset", reg_rdata, 8'h00);
        chk("R1 irq reset", {7'b0, irq_req}, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        // R4: reserved bits written with ones leave no trace.
        step(4'b0000, 1, 1, 8'h35, 0, 0, 1, "R4 mask rsvd");
        step(4'b0000, 1, 0, 8'h35, 0, 0, 1, "R4 flag rsvd");
        // R2 each event alone, then R5 enable all.
        for (int s = 0; s < 4; s++) step(4'(1 << s), 0, 0, 0, 0, 0, 1, "R2 single");
        step(4'b0000, 1, 1, 8'hFF, 0, 0, 0, "R6 gie off");
        step(4'b0000, 0, 0, 0, 0, 0, 1, "R7 all pending");
        // R8 acknowledge sequence in priority order, plus a non-matching ack.
        step(4'b0000, 0, 0, 0, 1, 4'd9, 1, "R8 nomatch");
        step(4'b0000, 0, 0, 0, 1, 4'd3, 1, "R8 ack cap");
        step(4'b0000, 0, 0, 0, 1, 4'd4, 1, "R8 ack cmpa");
        // R3 write-one clear of one flag only.
        step(4'b0000, 1, 0, 8'h80, 0, 0, 1, "R3 w1c");
        // R9 set wins over write clear and over ack.
        step(4'b1000, 1, 0, 8'h02, 0, 0, 1, "R9 set vs write");
        step(4'b1000, 0, 0, 0, 1, 4'd6, 1, "R9 set vs ack");
        step(4'b0000, 1, 0, 8'hFF, 0, 0, 1, "R10 cleared");

        for (int i = 0; i < 600; i++) begin
            step(4'($urandom_range(0, 15) & $urandom_range(0, 15)),
                 ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                 8'($urandom), ($urandom_range(0, 2) == 0),
                 4'($urandom_range(2, 7)), ($urandom_range(0, 4) != 0), "rand");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule